// File: doc/BRIEF.md
# Free-Running SPI Word Streamer

This block is an SPI bus master that sends data to a host whose SPI port acts as a slave and packs everything it receives into 32-bit words. Bytes enter through a valid/ready stream. They are gathered four at a time into a word. Each finished word goes into a small word FIFO, and a serializer empties that FIFO onto MOSI. The serializer generates SCLK by dividing the system clock. The host never polls the block: the link runs whenever the FIFO holds a word and the enable input is high.

The receiver aligns words only by counting clock pulses, so this block never emits a partial word and never toggles SCLK while idle. Chip-select is tied active. An optional byte swap puts the first byte of each group of four in the low byte of the word. A little-endian host then finds the byte stream in memory in its original order.

Top module: `spi_word_streamer`

## Requirements
- R1: `cs_no` is low at all times, including during reset.
- R2: SCLK idles low. Every word is exactly 32 rising SCLK edges. While `busy_o` is low there are no SCLK edges, so the total edge count is always a multiple of 32 when the link is idle.
- R3: SPI mode 0 is used. MOSI presents the word MSB first and changes only while SCLK is low, so the receiver samples each bit on the rising edge.
- R4: With `swap_en_i` low, the first byte accepted for a word is placed in bits 31:24 and the fourth byte in bits 7:0.
- R5: With `swap_en_i` high (sampled when the fourth byte completes the word), the byte order is reversed: the first byte goes to bits 7:0 and is sent last, and the fourth byte goes to bits 31:24.
- R6: A word is sent only after four bytes have been gathered. With fewer bytes pending, SCLK stays low and `busy_o` stays low.
- R7: Each SCLK high phase and each SCLK low phase lasts `div_i`+1 system clock cycles. `div_i` is sampled when a word starts.
- R8: When the next word is already queued as a word ends, it follows at once. The low phase between the two words is also `div_i`+1 cycles, and `busy_o` stays high across the boundary.
- R9: Dropping `enable_i` in the middle of a word lets that word finish all 32 pulses. No new word starts while `enable_i` is low.
- R10: `busy_o` is high while a word is being shifted. `words_sent_o` increases by exactly one for each word that completes.
- R11: `byte_ready_o` goes low only when both the FIFO and the byte gatherer are full. No accepted byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Allows new words to start |
| swap_en_i | input | 1 | Reverses byte order within each word |
| div_i | input | DIV_W | Half-period length minus one, in system clocks |
| byte_data_i | input | BYTE_W | Incoming byte |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_ready_o | output | 1 | Block can accept a byte |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI serial data out |
| cs_no | output | 1 | Chip-select, permanently active low |
| busy_o | output | 1 | A word is being shifted |
| words_sent_o | output | CNT_W | Count of completed words |

## Verification
The bench uses the default 32-bit word, 8-bit bytes and an 8-bit divider, with the FIFO depth set explicitly to 4 words. Four words of storage make the full condition reachable after a short burst of 20 bytes, so R11 can be tested. Divider values 0, 1, 2 and 3 cover the narrowest SCLK pulses, where the word-end handover has no slack cycles, as well as wider pulses. Word lengths of 192 cycles are long enough to drop the enable mid-word and to have a second word queued before the first one ends.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  typedef enum logic [0:0] {SER_IDLE, SER_SHIFT} ser_state_e;
endpackage

// File: rtl/ws_byte_packer.sv
module ws_byte_packer #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  localparam int WORD_W = BYTE_W * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  input  logic              word_ready_i
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] raw_q;
  logic [WORD_W-1:0] swapped;
  logic              accept, push;

  assign word_valid_o = (cnt_q == CW'(BYTES));
  // a full gatherer can still take a byte in the cycle it hands its word over
  assign ready_o      = !word_valid_o || word_ready_i;
  assign accept       = valid_i && ready_o;
  assign push         = word_valid_o && word_ready_i;

  for (genvar g = 0; g < BYTES; g++) begin : g_swap
    assign swapped[g*BYTE_W +: BYTE_W] = raw_q[(BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign word_o = swap_i ? swapped : raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      raw_q <= '0;
    end else begin
      if (accept) raw_q <= {raw_q[WORD_W-BYTE_W-1:0], data_i};
      if (push)        cnt_q <= accept ? CW'(1) : '0;
      else if (accept) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ws_word_fifo.sv
module ws_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/ws_serializer.sv
module ws_serializer
  import spi_stream_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_take_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  words_sent_o
);
  localparam int BIT_W = $clog2(WORD_W);

  ser_state_e        state_q;
  logic [DIV_W-1:0]  div_q, hcnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              sclk_q;
  logic [CNT_W-1:0]  sent_q;
  logic              half_done, last_fall, start;

  assign half_done = (state_q == SER_SHIFT) && (hcnt_q == div_q);
  assign last_fall = half_done && sclk_q && (bit_q == BIT_W'(WORD_W - 1));
  // start from idle, or chain straight onto the final falling edge
  assign start     = enable_i && word_valid_i && ((state_q == SER_IDLE) || last_fall);

  assign word_take_o  = start;
  assign sclk_o       = sclk_q;
  assign mosi_o       = sh_q[WORD_W-1];
  assign busy_o       = (state_q == SER_SHIFT);
  assign words_sent_o = sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SER_IDLE;
      div_q   <= '0;
      hcnt_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      sclk_q  <= 1'b0;
      sent_q  <= '0;
    end else if (start) begin
      if (state_q == SER_SHIFT) sent_q <= sent_q + 1'b1;
      state_q <= SER_SHIFT;
      sh_q    <= word_i;
      div_q   <= div_i;
      hcnt_q  <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
    end else if (state_q == SER_SHIFT) begin
      if (!half_done) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        hcnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (last_fall) begin
            state_q <= SER_IDLE;
            sent_q  <= sent_q + 1'b1;
            sh_q    <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_streamer.sv
module spi_word_streamer #(
  parameter int BYTE_W     = 8,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              swap_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic [CNT_W-1:0]  words_sent_o
);
  localparam int BYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] pk_word, fifo_word;
  logic              pk_valid, fifo_full, fifo_empty, take;

  assign cs_no = 1'b0;

  ws_byte_packer #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_packer (
    .clk_i, .rst_ni,
    .swap_i       (swap_en_i),
    .data_i       (byte_data_i),
    .valid_i      (byte_valid_i),
    .ready_o      (byte_ready_o),
    .word_o       (pk_word),
    .word_valid_o (pk_valid),
    .word_ready_i (!fifo_full)
  );

  ws_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (pk_valid),
    .data_i  (pk_word),
    .full_o  (fifo_full),
    .pop_i   (take),
    .data_o  (fifo_word),
    .empty_o (fifo_empty)
  );

  ws_serializer #(.WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_ser (
    .clk_i, .rst_ni,
    .enable_i,
    .div_i,
    .word_i       (fifo_word),
    .word_valid_i (!fifo_empty),
    .word_take_o  (take),
    .sclk_o,
    .mosi_o,
    .busy_o,
    .words_sent_o
  );
endmodule

// File: rtl/spi_word_streamer_chk.sv
module spi_word_streamer_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             cs_no,
  input logic             busy_o,
  input logic [CNT_W-1:0] words_sent_o
);
  localparam int BIT_W = $clog2(WORD_W);

  logic             sclk_d;
  logic [BIT_W-1:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_cs_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no == 1'b0);

  assert_idle_sclk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  assert_whole_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> rise_cnt == '0);

  assert_mosi_stable_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_start_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enable_i));

  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (words_sent_o != $past(words_sent_o)) |-> (words_sent_o == $past(words_sent_o) + 1'b1));
endmodule

bind spi_word_streamer spi_word_streamer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .enable_i, .sclk_o, .mosi_o, .cs_no, .busy_o, .words_sent_o
);

// File: tb/spi_word_streamer_bench.sv
`timescale 1ns/1ps
module spi_word_streamer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        swap_en_i = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic [7:0]  byte_data_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o, sclk_o, mosi_o, cs_no, busy_o;
  logic [15:0] words_sent_o;

  always #2.5 clk_i = ~clk_i;

  spi_word_streamer #(.FIFO_DEPTH(4)) u_spi_word_streamer (.*);

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // receiver model and line monitor
  logic [31:0] rx [0:63];
  int          rx_n = 0, bits = 0, busy_falls = 0;
  int          cs_err = 0, mode_err = 0, idle_err = 0;
  int          run = 0, hi_min, hi_max, lo_min, lo_max;
  logic [31:0] shreg = '0;
  logic        p_sclk = 1'b0, p_mosi = 1'b0, p_busy = 1'b0, in_stream = 1'b0;

  task automatic reset_stats();
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0; busy_falls = 0;
  endtask

  always @(negedge clk_i) begin
    if (cs_no !== 1'b0) cs_err++;
    if (rst_ni) begin
      if (sclk_o && p_sclk && mosi_o !== p_mosi) mode_err++;
      if (!busy_o && sclk_o) idle_err++;
      if (p_busy && !busy_o) busy_falls++;
      if (sclk_o && !p_sclk) begin
        shreg = {shreg[30:0], mosi_o};
        bits++;
        if (bits == 32) begin rx[rx_n] = shreg; rx_n++; bits = 0; end
      end
      if (sclk_o !== p_sclk) begin
        if (p_sclk) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
        end else if (in_stream) begin
          if (run < lo_min) lo_min = run;
          if (run > lo_max) lo_max = run;
        end
        if (!sclk_o) in_stream = 1'b1;
        run = 1;
      end else run++;
      if (!busy_o) in_stream = 1'b0;
    end
    p_sclk = sclk_o; p_mosi = mosi_o; p_busy = busy_o;
  end

  task automatic check(input bit ok, input string req, input string msg);
    n_checks++;
    if (!ok) begin n_fail++; $display("FAIL %s: %s", req, msg); end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk_i);
    byte_data_i = d; byte_valid_i = 1'b1;
    while (!byte_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);  // w[31:24] sent as first byte
    for (int i = 3; i >= 0; i--) push_byte(w[i*8 +: 8]);
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_n < n && t < 20000) begin @(negedge clk_i); t++; end
    while (busy_o && t < 20000) begin @(negedge clk_i); t++; end
    repeat (4) @(negedge clk_i);
    check(rx_n >= n, "R10", $sformatf("words received %0d expected %0d", rx_n, n));
  endtask

  task automatic test_reset();
    check(sclk_o === 1'b0 && busy_o === 1'b0 && mosi_o === 1'b0, "R2",
          $sformatf("reset sclk/busy/mosi %b%b%b expected 000", sclk_o, busy_o, mosi_o));
    check(cs_no === 1'b0, "R1", $sformatf("cs_no %b expected 0", cs_no));
    check(words_sent_o === 16'd0, "R10", $sformatf("count %0d expected 0", words_sent_o));
    check(byte_ready_o === 1'b1, "R11", $sformatf("ready %b expected 1", byte_ready_o));
  endtask

  task automatic test_plain();
    int b = rx_n;
    enable_i = 1'b1; swap_en_i = 1'b0; div_i = 8'd1;
    push_word(32'hA1B2C3D4);
    push_word(32'h5E6F7081);
    wait_rx(b + 2);
    check(rx[b] === 32'hA1B2C3D4, "R4", $sformatf("word %h expected a1b2c3d4", rx[b]));
    check(rx[b+1] === 32'h5E6F7081, "R3", $sformatf("word %h expected 5e6f7081", rx[b+1]));
    check(words_sent_o === 16'(b + 2), "R10", $sformatf("count %0d expected %0d", words_sent_o, b + 2));
    check(bits == 0, "R2", $sformatf("stray edges %0d expected 0", bits));
  endtask

  task automatic test_swap();
    int b = rx_n;
    swap_en_i = 1'b1;
    push_word(32'h11223344);
    wait_rx(b + 1);
    check(rx[b] === 32'h44332211, "R5", $sformatf("word %h expected 44332211", rx[b]));
    swap_en_i = 1'b0;
  endtask

  task automatic test_partial();
    int b = rx_n;
    push_byte(8'hC0); push_byte(8'hC1); push_byte(8'hC2);
    repeat (100) @(negedge clk_i);
    check(rx_n == b && bits == 0 && !busy_o && !sclk_o, "R6",
          $sformatf("with 3 bytes words %0d bits %0d busy %b expected %0d,0,0", rx_n, bits, busy_o, b));
    push_byte(8'hC3);
    wait_rx(b + 1);
    check(rx[b] === 32'hC0C1C2C3, "R6", $sformatf("word %h expected c0c1c2c3", rx[b]));
  endtask

  task automatic test_div(input logic [7:0] d);
    int b = rx_n;
    div_i = d; reset_stats();
    push_word(32'h0F0F55AA);
    wait_rx(b + 1);
    check(hi_min == d + 1 && hi_max == d + 1 && lo_min == d + 1 && lo_max == d + 1, "R7",
          $sformatf("div %0d high %0d..%0d low %0d..%0d expected %0d", d, hi_min, hi_max, lo_min, lo_max, d + 1));
    check(rx[b] === 32'h0F0F55AA, "R7", $sformatf("word %h expected 0f0f55aa", rx[b]));
  endtask

  task automatic test_b2b();
    int b = rx_n;
    div_i = 8'd2; reset_stats();
    push_word(32'h01020304); push_word(32'h05060708); push_word(32'h090A0B0C);
    wait_rx(b + 3);
    check(busy_falls == 1, "R8", $sformatf("busy drops %0d expected 1", busy_falls));
    check(lo_min == 3 && lo_max == 3, "R8", $sformatf("low phase %0d..%0d expected 3", lo_min, lo_max));
    check(rx[b+2] === 32'h090A0B0C, "R8", $sformatf("word %h expected 090a0b0c", rx[b+2]));
  endtask

  task automatic test_enable();
    int b = rx_n;
    div_i = 8'd2;
    push_word(32'hDEADBEEF); push_word(32'hCAFEF00D);
    while (!(busy_o && bits >= 5)) @(negedge clk_i);
    enable_i = 1'b0;
    repeat (300) @(negedge clk_i);
    check(rx_n == b + 1 && bits == 0 && !busy_o, "R9",
          $sformatf("after disable words %0d bits %0d busy %b expected %0d,0,0", rx_n, bits, busy_o, b + 1));
    check(rx[b] === 32'hDEADBEEF, "R9", $sformatf("word %h expected deadbeef", rx[b]));
    enable_i = 1'b1;
    wait_rx(b + 2);
    check(rx[b+1] === 32'hCAFEF00D, "R9", $sformatf("word %h expected cafef00d", rx[b+1]));
  endtask

  task automatic test_flow();
    int b = rx_n, acc = 0;
    enable_i = 1'b0; div_i = 8'd0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i);
      if (!byte_ready_o) break;
      byte_data_i = 8'h40 + 8'(i); byte_valid_i = 1'b1;
      @(negedge clk_i);
      byte_valid_i = 1'b0; acc++;
    end
    check(acc == 20, "R11", $sformatf("accepted %0d expected 20", acc));
    check(byte_ready_o === 1'b0, "R11", $sformatf("ready %b expected 0", byte_ready_o));
    enable_i = 1'b1;
    wait_rx(b + 5);
    for (int w = 0; w < 5; w++) begin
      logic [31:0] e;
      for (int k = 0; k < 4; k++) e[(3-k)*8 +: 8] = 8'h40 + 8'(w*4 + k);
      check(rx[b+w] === e, "R11", $sformatf("word %0d %h expected %h", w, rx[b+w], e));
    end
  endtask

  initial begin
    reset_stats();
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    test_plain();
    test_swap();
    test_partial();
    test_div(8'd0);
    test_div(8'd3);
    test_b2b();
    test_enable();
    test_flow();
    check(cs_err == 0, "R1", $sformatf("cs high samples %0d expected 0", cs_err));
    check(mode_err == 0, "R3", $sformatf("mosi changes in high phase %0d expected 0", mode_err));
    check(idle_err == 0 && bits == 0, "R2", $sformatf("idle edges %0d leftover bits %0d expected 0", idle_err, bits));
    check(words_sent_o === 16'(rx_n), "R10", $sformatf("count %0d expected %0d", words_sent_o, rx_n));
    summary();
  end
endmodule